// File: doc/BRIEF.md
# Shared FM0 / Manchester Line Encoder

This block turns one serial data stream into a coded line level, in either FM0 (bi-phase space) or Manchester code, as chosen by a mode input. It runs on a system clock at twice the bit rate. An internal half-bit phase flag takes the place of the bit clock: each bit occupies one first-half cycle and one second-half cycle. Both codes share one next-level multiplexer and one output flip-flop. FM0 keeps its history in a single state flip-flop.

A bit starts only when the bit-valid strobe is high while the encoder is in its first half. Data and mode are captured at that point. The second half then always follows, whatever the strobe does. When no bit starts, the line rests at an idle level, low by default, and the FM0 history is left untouched. The line level for a bit appears one system clock after the edge that sampled it.

Top module: `fm0_manch_enc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives line_out to the idle level (0 by default) and returns the encoder to the first half. It also clears the FM0 history, so the first FM0 bit after reset opens with a high first half.
- R2: In FM0 mode (mode_sel = 0), the first-half level of a bit is the inverse of the second-half level of the previous FM0 bit. Every FM0 bit boundary therefore carries a transition.
- R3: In FM0 mode, a data bit of 0 gives a second-half level that is the inverse of its first half. A data bit of 1 gives a second half equal to its first half.
- R4: In Manchester mode (mode_sel = 1), the first half of a bit is the inverse of the data bit and the second half equals the data bit. This is data XOR a bit clock that is high in the first half.
- R5: din and mode_sel are captured only at the clock edge that starts a bit. Changes to them during the second half have no effect on that bit.
- R6: Manchester bits leave the FM0 history unchanged. An FM0 bit that follows Manchester bits continues from the last FM0 second-half level.
- R7: When bit_vld is low at a first-half edge, no bit starts, line_out drives the idle level for that cycle, and the FM0 history is held.
- R8: line_out is registered. The level for a half-bit appears one system clock after the edge at which that half began.
- R9: Once a bit has started, its second half is always emitted in the next cycle, whatever the value of bit_vld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Starts a bit when high in the first half |
| mode_sel | input | 1 | Code select: 0 = FM0, 1 = Manchester |
| din | input | 1 | Serial data bit |
| line_out | output | 1 | Registered coded line level |

## Verification
The bench alternates the two codes so that FM0 history has to survive runs of Manchester bits. A design that advanced the state in Manchester mode would give the wrong boundary level on the next FM0 bit. It flips mode_sel and din during second halves and drops bit_vld there. A design that read those inputs late would corrupt the second half or cut the bit short. Idle gaps between FM0 bits and a reset in mid-stream check that the history is held through idle and cleared only by reset, and each of these shows up as a wrong first-half level.

// File: rtl/fm0_manch_enc.sv
module fm0_manch_enc #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic mode_sel,
  input  logic din,
  output logic line_out
);

  logic half_q, x_q, m_q, b_q, line_q, lvl_nxt;

  wire start = !half_q && bit_vld;
  wire b_nxt = x_q ^ b_q;

  always_comb begin
    if (half_q)
      lvl_nxt = m_q ? x_q : b_nxt;
    else if (bit_vld)
      lvl_nxt = mode_sel ? ~din : ~b_q;
    else
      lvl_nxt = IDLE_LVL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      x_q    <= 1'b0;
      m_q    <= 1'b0;
      b_q    <= 1'b0;
      line_q <= IDLE_LVL;
    end else begin
      line_q <= lvl_nxt;
      half_q <= start;
      if (start) begin
        x_q <= din;
        m_q <= mode_sel;
      end
      if (half_q && !m_q)
        b_q <= b_nxt;
    end
  end

  assign line_out = line_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (line_out == IDLE_LVL) && !half_q && !b_q);

  p_fm0_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    (!half_q && bit_vld && !mode_sel) |=> (line_out == !$past(b_q)));

  p_fm0_midbit_r3: assert property (@(posedge clk) disable iff (rst)
    (!half_q && bit_vld && !mode_sel) |=> ##1 (line_out == ($past(line_out) ^ !$past(din, 2))));

  p_manch_halves_r4: assert property (@(posedge clk) disable iff (rst)
    (!half_q && bit_vld && mode_sel) |=> (line_out == !$past(din)) ##1 (line_out == $past(din, 2)));

  p_manch_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
    (half_q && m_q) |=> $stable(b_q));

  p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
    (!half_q && !bit_vld) |=> (line_out == IDLE_LVL) && $stable(b_q));

  p_second_half_r9: assert property (@(posedge clk) disable iff (rst)
    (!half_q && bit_vld) |=> half_q);

endmodule

// File: tb/fm0_manch_enc_tb_top.sv
module fm0_manch_enc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic mode_sel = 1'b0;
  logic din = 1'b0;
  logic line_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit exp_lvl = 0;
  bit fm_last = 0;
  bit pend_q[$];

  always #4 clk = ~clk;

  fm0_manch_enc dut_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld),
    .mode_sel(mode_sel), .din(din), .line_out(line_out)
  );

  task automatic model();
    bit f, s;
    if (rst) begin
      pend_q.delete();
      fm_last = 0;
      exp_lvl = 0;
    end else if (pend_q.size() != 0) begin
      exp_lvl = pend_q.pop_front();
    end else if (bit_vld) begin
      if (!mode_sel) begin
        f = !fm_last;
        s = din ? f : !f;
        fm_last = s;
      end else begin
        f = !din;
        s = din;
      end
      pend_q.push_back(s);
      exp_lvl = f;
    end else begin
      exp_lvl = 0;
    end
  endtask

  task automatic step(input bit r, input bit v, input bit m, input bit d, input string tag);
    rst = r; bit_vld = v; mode_sel = m; din = d;
    @(posedge clk);
    model();
    @(negedge clk);
    total++;
    if (line_out !== exp_lvl) begin
      bad++;
      $display("FAIL %s t=%0t got=%0b exp=%0b", tag, $time, line_out, exp_lvl);
    end
  endtask

  task automatic fm0_bit(input bit d, input string tag);
    step(0, 1, 0, d, tag);
    step(0, 0, 0, d, tag);
  endtask

  task automatic man_bit(input bit d, input string tag);
    step(0, 1, 1, d, tag);
    step(0, 0, 1, d, tag);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 1, 0, 1, "R1 reset");
    step(1, 0, 1, 0, "R1 reset");
    step(0, 0, 0, 0, "R1 idle after reset");
    fm0_bit(1, "R1 first fm0 bit high");
    fm0_bit(1, "R2 boundary");
    fm0_bit(0, "R3 mid-bit zero");
    fm0_bit(0, "R3 mid-bit zero");
    fm0_bit(1, "R2 boundary after zero");
    step(0, 0, 0, 1, "R7 idle");
    step(0, 0, 1, 0, "R7 idle");
    fm0_bit(1, "R7 history held over idle");
    man_bit(1, "R4 manchester one");
    man_bit(0, "R4 manchester zero");
    man_bit(0, "R4 manchester zero");
    fm0_bit(0, "R6 fm0 after manchester");
    step(0, 1, 0, 1, "R5 start fm0");
    step(0, 1, 1, 0, "R5 R9 late mode and data ignored");
    step(0, 1, 1, 1, "R5 start manchester");
    step(0, 0, 0, 0, "R5 R9 late changes ignored");
    fm0_bit(1, "R6 history after mixed");
    for (int i = 0; i < 40; i++) begin
      bit d = ((i * 7 + 3) % 5) < 2;
      bit m = (i % 3) == 2;
      if (i % 7 == 6)
        step(0, 0, m, d, "R7 idle gap");
      else begin
        step(0, 1, m, d, "R8 first half");
        step(0, (i % 2) == 0, !m, !d, "R9 second half");
      end
    end
    step(0, 1, 0, 0, "R5 start before reset");
    step(1, 0, 0, 0, "R1 reset mid-bit");
    step(0, 0, 0, 0, "R1 idle after reset");
    fm0_bit(0, "R1 history cleared");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule